// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command-register state machine of a NOR-style flash device model. It watches a synchronous write port made of a write strobe, an address and a data byte. It recognises the multi-cycle command sequences written to it: a four-cycle sequence that switches the read path into burst mode, a second four-cycle sequence that switches it back, single-write erase-suspend and erase-resume commands, and a single-write software reset. The memory array, the embedded algorithms and all analog timing are outside this block.

The read path uses the level outputs. `burst_mode` and `erase_suspend` tell it which mode to be in. `rd_sel_status` tells it to return status data instead of array data. `seq_idle` is high when no partial sequence is held. Each accepted command also produces a one-cycle pulse.

A power-on reset (`por_n`) and a synchronous hardware reset input (`hw_reset`) both return every flag to its power-up value. The software reset command does not clear burst mode. A rising edge on the status error input locks the decoder in a status-hold state, and only the software reset command releases it.

States: `ST_ARRAY` (array read, no partial sequence), `ST_UNLOCKED1` (first unlock write seen), `ST_UNLOCKED2` (both unlock writes seen), `ST_BURST_ON3` (burst-enable third write seen), `ST_BURST_OFF3` (burst-disable third write seen), `ST_STATUS_HOLD` (error lock).

Transitions, with a write meaning a cycle where `wr_en` is high:
- ARRAY_TO_U1: data 0xAA at address 0x555, from `ST_ARRAY`.
- U1_TO_U2: data 0x55 at address 0x2AA, from `ST_UNLOCKED1`.
- U2_TO_ON3: data 0xC0 at address 0x555, from `ST_UNLOCKED2`.
- U2_TO_OFF3: data 0xD0 at address 0x555, from `ST_UNLOCKED2`.
- CONFIRM: data 0x01 at address 0x000, from `ST_BURST_ON3` or `ST_BURST_OFF3`, returning to `ST_ARRAY`.
- ABORT: any other write in `ST_UNLOCKED1`, `ST_UNLOCKED2`, `ST_BURST_ON3` or `ST_BURST_OFF3`, returning to `ST_ARRAY`.
- SOFT_RESET: data 0xF0 at any address, from any state, returning to `ST_ARRAY`.
- TO_HOLD: a rising edge of `status_err`, from any state.
- HW_RESET: `hw_reset` high, from any state, returning to `ST_ARRAY`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After power-on reset, `seq_idle`=1, `burst_mode`=0, `erase_suspend`=0, `rd_sel_status`=0 and every pulse output is 0.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xC0@0x555, 0x01@0x000 set `burst_mode`. `pulse_burst_on` is high for exactly the one cycle after the fourth write.
- R3: The writes 0xAA@0x555, 0x55@0x2AA, 0xD0@0x555, 0x01@0x000 clear `burst_mode`. `pulse_burst_off` is high for exactly the one cycle after the fourth write.
- R4: A wrong address or data at any step of a sequence returns the decoder to `ST_ARRAY` (`seq_idle`=1 the next cycle). The partial sequence is discarded, and the flags do not change.
- R5: Cycles with `wr_en` low change neither the sequence state nor the flags.
- R6: A write of 0xF0 at any address in any state returns the decoder to `ST_ARRAY` and pulses `pulse_soft_reset`. It leaves `burst_mode` and `erase_suspend` unchanged.
- R7: `hw_reset` high at a clock edge clears `burst_mode` and `erase_suspend` and returns the decoder to `ST_ARRAY`.
- R8: In `ST_ARRAY`, a write of 0xB0 (any address) sets `erase_suspend` and pulses `pulse_suspend`. A write of 0x30 (any address) clears it and pulses `pulse_resume`. Inside a sequence, these writes abort the sequence as in R4.
- R9: A rising edge of `status_err` moves the decoder to `ST_STATUS_HOLD` (`seq_idle`=0, `rd_sel_status`=1). There, writes other than 0xF0 are ignored, and only 0xF0 leaves.
- R10: `rd_sel_status` is high combinationally when in `ST_STATUS_HOLD`, or when `erase_suspend` and `rd_in_susp_sector` are both high.
- R11: At most one pulse output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_reset | input | 1 | Synchronous hardware reset, active high |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| status_err | input | 1 | Status error bit from the embedded algorithm |
| rd_in_susp_sector | input | 1 | Current read address lies in a suspended sector |
| seq_idle | output | 1 | Decoder in `ST_ARRAY` |
| burst_mode | output | 1 | Burst read mode flag |
| erase_suspend | output | 1 | Erase-suspend mode flag |
| rd_sel_status | output | 1 | Read path returns status instead of array data |
| pulse_burst_on | output | 1 | Burst-enable sequence accepted |
| pulse_burst_off | output | 1 | Burst-disable sequence accepted |
| pulse_soft_reset | output | 1 | Software reset command accepted |
| pulse_suspend | output | 1 | Erase-suspend command accepted |
| pulse_resume | output | 1 | Erase-resume command accepted |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable around its rising edge. They also assume that `hw_reset` and a write never need a defined interaction beyond reset taking priority. The bench drives every input on the falling edge and keeps one write per strobe cycle, which satisfies both assumptions. It raises `status_err` only while no write is being presented, so an error edge and a write never meet in one cycle. It samples registered outputs at the falling edge after the write's rising edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY       = 3'd0,
        ST_UNLOCKED1   = 3'd1,
        ST_UNLOCKED2   = 3'd2,
        ST_BURST_ON3   = 3'd3,
        ST_BURST_OFF3  = 3'd4,
        ST_STATUS_HOLD = 3'd5
    } seq_state_t;

    // One flag per write pattern the decoder knows, valid only with the strobe
    typedef struct packed {
        logic unlock1;
        logic unlock2;
        logic burst_on;
        logic burst_off;
        logic confirm;
        logic soft_reset;
        logic suspend;
        logic resume;
    } cyc_hit_t;

    // Accepted commands, at most one per cycle
    typedef struct packed {
        logic burst_on;
        logic burst_off;
        logic soft_reset;
        logic suspend;
        logic resume;
    } cmd_event_t;

    localparam int unsigned CMD_EVENTS = $bits(cmd_event_t);

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
    import flash_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W       = 11,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned UNLOCK1_ADDR = 'h555,
    parameter int unsigned UNLOCK2_ADDR = 'h2AA,
    parameter int unsigned CONFIRM_ADDR = 'h000,
    parameter bit          FULL_ADDR_CHECK = 1'b1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cyc_hit_t          hit
);

    localparam logic [ADDR_W-1:0] A_UNLK1   = ADDR_W'(UNLOCK1_ADDR);
    localparam logic [ADDR_W-1:0] A_UNLK2   = ADDR_W'(UNLOCK2_ADDR);
    localparam logic [ADDR_W-1:0] A_CONFIRM = ADDR_W'(CONFIRM_ADDR);

    localparam logic [DATA_W-1:0] D_UNLK1   = DATA_W'(8'hAA);
    localparam logic [DATA_W-1:0] D_UNLK2   = DATA_W'(8'h55);
    localparam logic [DATA_W-1:0] D_BON     = DATA_W'(8'hC0);
    localparam logic [DATA_W-1:0] D_BOFF    = DATA_W'(8'hD0);
    localparam logic [DATA_W-1:0] D_CONFIRM = DATA_W'(8'h01);
    localparam logic [DATA_W-1:0] D_RESET   = DATA_W'(8'hF0);
    localparam logic [DATA_W-1:0] D_SUSP    = DATA_W'(8'hB0);
    localparam logic [DATA_W-1:0] D_RESUME  = DATA_W'(8'h30);

    logic at_unlk1;
    logic at_unlk2;
    logic at_confirm;

    generate
        if (FULL_ADDR_CHECK) begin : g_full
            assign at_unlk1   = (wr_addr == A_UNLK1);
            assign at_unlk2   = (wr_addr == A_UNLK2);
            assign at_confirm = (wr_addr == A_CONFIRM);
        end else begin : g_low11
            localparam int unsigned CW = (ADDR_W < 11) ? ADDR_W : 11;
            assign at_unlk1   = (wr_addr[CW-1:0] == A_UNLK1[CW-1:0]);
            assign at_unlk2   = (wr_addr[CW-1:0] == A_UNLK2[CW-1:0]);
            assign at_confirm = (wr_addr[CW-1:0] == A_CONFIRM[CW-1:0]);
        end
    endgenerate

    always_comb begin
        hit            = '0;
        hit.unlock1    = wr_en && at_unlk1   && (wr_data == D_UNLK1);
        hit.unlock2    = wr_en && at_unlk2   && (wr_data == D_UNLK2);
        hit.burst_on   = wr_en && at_unlk1   && (wr_data == D_BON);
        hit.burst_off  = wr_en && at_unlk1   && (wr_data == D_BOFF);
        hit.confirm    = wr_en && at_confirm && (wr_data == D_CONFIRM);
        hit.soft_reset = wr_en && (wr_data == D_RESET);
        hit.suspend    = wr_en && (wr_data == D_SUSP);
        hit.resume     = wr_en && (wr_data == D_RESUME);
    end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       hw_reset,
    input  logic       wr_en,
    input  cyc_hit_t   hit,
    input  logic       status_err,
    output seq_state_t state,
    output cmd_event_t event_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       err_q;
    logic       err_rise;

    assign err_rise = status_err && !err_q;
    assign state    = state_q;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_ARRAY;
            err_q   <= 1'b0;
        end else begin
            err_q <= status_err;
            if (hw_reset) begin
                state_q <= ST_ARRAY;
            end else begin
                state_q <= state_d;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (hit.soft_reset) begin
            state_d = ST_ARRAY;
        end else if (err_rise) begin
            state_d = ST_STATUS_HOLD;
        end else if (wr_en) begin
            unique case (state_q)
                ST_ARRAY:       state_d = hit.unlock1 ? ST_UNLOCKED1 : ST_ARRAY;
                ST_UNLOCKED1:   state_d = hit.unlock2 ? ST_UNLOCKED2 : ST_ARRAY;
                ST_UNLOCKED2: begin
                    if (hit.burst_on) begin
                        state_d = ST_BURST_ON3;
                    end else if (hit.burst_off) begin
                        state_d = ST_BURST_OFF3;
                    end else begin
                        state_d = ST_ARRAY;
                    end
                end
                ST_BURST_ON3:   state_d = ST_ARRAY;
                ST_BURST_OFF3:  state_d = ST_ARRAY;
                ST_STATUS_HOLD: state_d = ST_STATUS_HOLD;
                default:        state_d = ST_ARRAY;
            endcase
        end
    end

    // Command events
    always_comb begin
        event_o = '0;
        if (hit.soft_reset) begin
            event_o.soft_reset = 1'b1;
        end else if (!err_rise && wr_en) begin
            unique case (state_q)
                ST_ARRAY: begin
                    event_o.suspend = hit.suspend;
                    event_o.resume  = hit.resume;
                end
                ST_BURST_ON3:  event_o.burst_on  = hit.confirm;
                ST_BURST_OFF3: event_o.burst_off = hit.confirm;
                ST_UNLOCKED1, ST_UNLOCKED2, ST_STATUS_HOLD: event_o = '0;
                default:       event_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/fcd_mode_flags.sv
module fcd_mode_flags
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       hw_reset,
    input  cmd_event_t event_i,
    output logic       burst_mode,
    output logic       erase_suspend,
    output cmd_event_t pulse
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            burst_mode    <= 1'b0;
            erase_suspend <= 1'b0;
            pulse         <= '0;
        end else if (hw_reset) begin
            burst_mode    <= 1'b0;
            erase_suspend <= 1'b0;
            pulse         <= '0;
        end else begin
            pulse <= event_i;
            if (event_i.burst_on) begin
                burst_mode <= 1'b1;
            end else if (event_i.burst_off) begin
                burst_mode <= 1'b0;
            end
            if (event_i.suspend) begin
                erase_suspend <= 1'b1;
            end else if (event_i.resume) begin
                erase_suspend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W       = 11,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned UNLOCK1_ADDR = 'h555,
    parameter int unsigned UNLOCK2_ADDR = 'h2AA,
    parameter int unsigned CONFIRM_ADDR = 'h000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              status_err,
    input  logic              rd_in_susp_sector,
    output logic              seq_idle,
    output logic              burst_mode,
    output logic              erase_suspend,
    output logic              rd_sel_status,
    output logic              pulse_burst_on,
    output logic              pulse_burst_off,
    output logic              pulse_soft_reset,
    output logic              pulse_suspend,
    output logic              pulse_resume
);

    cyc_hit_t   hit;
    seq_state_t state;
    cmd_event_t cmd_event;
    cmd_event_t pulse;

    fcd_cycle_match #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .UNLOCK1_ADDR (UNLOCK1_ADDR),
        .UNLOCK2_ADDR (UNLOCK2_ADDR),
        .CONFIRM_ADDR (CONFIRM_ADDR),
        .FULL_ADDR_CHECK (1'b1)
    ) u_match (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit)
    );

    fcd_seq_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .hw_reset   (hw_reset),
        .wr_en      (wr_en),
        .hit        (hit),
        .status_err (status_err),
        .state      (state),
        .event_o    (cmd_event)
    );

    fcd_mode_flags u_flags (
        .clk           (clk),
        .por_n         (por_n),
        .hw_reset      (hw_reset),
        .event_i       (cmd_event),
        .burst_mode    (burst_mode),
        .erase_suspend (erase_suspend),
        .pulse         (pulse)
    );

    assign seq_idle         = (state == ST_ARRAY);
    assign rd_sel_status    = (state == ST_STATUS_HOLD) || (erase_suspend && rd_in_susp_sector);
    assign pulse_burst_on   = pulse.burst_on;
    assign pulse_burst_off  = pulse.burst_off;
    assign pulse_soft_reset = pulse.soft_reset;
    assign pulse_suspend    = pulse.suspend;
    assign pulse_resume     = pulse.resume;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int unsigned ADDR_W       = 11,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned CONFIRM_ADDR = 'h000
) (
    input logic              clk,
    input logic              por_n,
    input logic              hw_reset,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              seq_idle,
    input logic              burst_mode,
    input logic              erase_suspend,
    input logic              pulse_burst_on,
    input logic              pulse_burst_off,
    input logic              pulse_soft_reset,
    input logic              pulse_suspend,
    input logic              pulse_resume
);

    localparam logic [DATA_W-1:0] K_RESET   = DATA_W'(8'hF0);
    localparam logic [DATA_W-1:0] K_CONFIRM = DATA_W'(8'h01);
    localparam logic [ADDR_W-1:0] K_CADDR   = ADDR_W'(CONFIRM_ADDR);

    logic confirm_wr;
    assign confirm_wr = wr_en && (wr_data == K_CONFIRM) && (wr_addr == K_CADDR);

    AST_BURST_ON_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (!por_n)
        $rose(burst_mode) |-> $past(confirm_wr && !hw_reset)); // R2

    AST_BURST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(burst_mode) |-> $past(hw_reset || confirm_wr)); // R3

    AST_SOFT_RESET_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wr_data == K_RESET && !hw_reset) |=>
            (burst_mode == $past(burst_mode)) && (erase_suspend == $past(erase_suspend)) && seq_idle); // R6

    AST_HW_RESET_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        hw_reset |=> (!burst_mode && !erase_suspend && seq_idle)); // R7

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_en && !hw_reset) |=> ($stable(burst_mode) && $stable(erase_suspend))); // R5

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({pulse_burst_on, pulse_burst_off, pulse_soft_reset, pulse_suspend, pulse_resume})); // R11

endmodule

bind flash_cmd_decoder fcd_checker #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .CONFIRM_ADDR (CONFIRM_ADDR)
) u_fcd_checker (
    .clk              (clk),
    .por_n            (por_n),
    .hw_reset         (hw_reset),
    .wr_en            (wr_en),
    .wr_addr          (wr_addr),
    .wr_data          (wr_data),
    .seq_idle         (seq_idle),
    .burst_mode       (burst_mode),
    .erase_suspend    (erase_suspend),
    .pulse_burst_on   (pulse_burst_on),
    .pulse_burst_off  (pulse_burst_off),
    .pulse_soft_reset (pulse_soft_reset),
    .pulse_suspend    (pulse_suspend),
    .pulse_resume     (pulse_resume)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

    localparam int unsigned AW = 11;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          hw_reset = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          status_err = 1'b0;
    logic          rd_in_susp_sector = 1'b0;
    logic          seq_idle, burst_mode, erase_suspend, rd_sel_status;
    logic          pulse_burst_on, pulse_burst_off, pulse_soft_reset, pulse_suspend, pulse_resume;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) i_flash_cmd_decoder (
        .clk(clk), .por_n(por_n), .hw_reset(hw_reset), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .status_err(status_err),
        .rd_in_susp_sector(rd_in_susp_sector), .seq_idle(seq_idle),
        .burst_mode(burst_mode), .erase_suspend(erase_suspend),
        .rd_sel_status(rd_sel_status), .pulse_burst_on(pulse_burst_on),
        .pulse_burst_off(pulse_burst_off), .pulse_soft_reset(pulse_soft_reset),
        .pulse_suspend(pulse_suspend), .pulse_resume(pulse_resume)
    );

    function automatic logic [4:0] pulses();
        return {pulse_burst_on, pulse_burst_off, pulse_soft_reset, pulse_suspend, pulse_resume};
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // One write: presented for one cycle, returns at the falling edge after it was taken
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic burst_seq(input logic [DW-1:0] third);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, third);
        wr(11'h000, 8'h01);
    endtask

    task automatic t_reset_state();
        check("R1 seq_idle", seq_idle, 1);
        check("R1 burst_mode", burst_mode, 0);
        check("R1 erase_suspend", erase_suspend, 0);
        check("R1 rd_sel_status", rd_sel_status, 0);
        check("R1 pulses", pulses(), 0);
    endtask

    task automatic t_burst_enable();
        wr(11'h555, 8'hAA);
        check("R2 mid-sequence not idle", seq_idle, 0);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'hC0);
        check("R2 no flag before confirm", burst_mode, 0);
        wr(11'h000, 8'h01);
        check("R2 burst_mode set", burst_mode, 1);
        check("R2 pulse_burst_on", pulses(), 5'b10000);
        idle(1);
        check("R2 pulse lasts one cycle", pulses(), 0);
        check("R2 idle after sequence", seq_idle, 1);
    endtask

    task automatic t_burst_disable();
        burst_seq(8'hD0);
        check("R3 burst_mode cleared", burst_mode, 0);
        check("R3 pulse_burst_off", pulses(), 5'b01000);
        idle(1);
        check("R3 pulse lasts one cycle", pulses(), 0);
    endtask

    task automatic t_abort();
        // wrong address at step 1
        wr(11'h554, 8'hAA);
        check("R4 step1 bad addr idle", seq_idle, 1);
        wr(11'h2AA, 8'h55); wr(11'h555, 8'hC0); wr(11'h000, 8'h01);
        check("R4 step1 abort no burst", burst_mode, 0);
        // wrong data at step 2
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56);
        check("R4 step2 bad data idle", seq_idle, 1);
        wr(11'h555, 8'hC0); wr(11'h000, 8'h01);
        check("R4 step2 abort no burst", burst_mode, 0);
        // wrong data at step 3
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hC1);
        check("R4 step3 bad data idle", seq_idle, 1);
        wr(11'h000, 8'h01);
        check("R4 step3 abort no burst", burst_mode, 0);
        // wrong address at step 4
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hC0); wr(11'h001, 8'h01);
        check("R4 step4 bad addr idle", seq_idle, 1);
        check("R4 step4 no burst, no pulse", {27'd0, pulses()} | {31'd0, burst_mode}, 0);
    endtask

    task automatic t_gaps();
        wr(11'h555, 8'hAA); idle(5);
        check("R5 idle cycles keep state", seq_idle, 0);
        wr(11'h2AA, 8'h55); idle(3);
        wr(11'h555, 8'hC0); idle(7);
        wr(11'h000, 8'h01);
        check("R5 gapped sequence sets burst", burst_mode, 1);
    endtask

    task automatic t_soft_reset();
        // burst_mode is 1 here
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
        wr(11'h123, 8'hF0);
        check("R6 reset returns idle", seq_idle, 1);
        check("R6 pulse_soft_reset", pulses(), 5'b00100);
        check("R6 burst kept", burst_mode, 1);
        wr(11'h000, 8'hB0);
        wr(11'h7FF, 8'hF0);
        check("R6 suspend kept", erase_suspend, 1);
        wr(11'h000, 8'h30);
    endtask

    task automatic t_suspend();
        wr(11'h3A5, 8'hB0);
        check("R8 erase_suspend set", erase_suspend, 1);
        check("R8 pulse_suspend", pulses(), 5'b00010);
        wr(11'h012, 8'h30);
        check("R8 erase_suspend cleared", erase_suspend, 0);
        check("R8 pulse_resume", pulses(), 5'b00001);
        wr(11'h555, 8'hAA); wr(11'h000, 8'hB0);
        check("R8 suspend inside sequence aborts", seq_idle, 1);
        check("R8 suspend inside sequence ignored", erase_suspend, 0);
        check("R8 no pulse on abort", pulses(), 0);
    endtask

    task automatic t_read_path();
        wr(11'h000, 8'hB0);
        rd_in_susp_sector = 1'b1; #1;
        check("R10 suspended sector selects status", rd_sel_status, 1);
        rd_in_susp_sector = 1'b0; #1;
        check("R10 other sector selects array", rd_sel_status, 0);
        wr(11'h000, 8'h30);
        rd_in_susp_sector = 1'b1; #1;
        check("R10 no suspend selects array", rd_sel_status, 0);
        rd_in_susp_sector = 1'b0;
    endtask

    task automatic t_err_hold();
        // burst_mode is 1 here
        @(negedge clk); status_err = 1'b1;
        @(negedge clk);
        check("R9 hold not idle", seq_idle, 0);
        check("R9 hold selects status", rd_sel_status, 1);
        burst_seq(8'hD0);
        check("R9 writes ignored in hold", burst_mode, 1);
        check("R9 still in hold", seq_idle, 0);
        wr(11'h044, 8'hF0);
        check("R9 reset leaves hold", seq_idle, 1);
        check("R9 status deselected", rd_sel_status, 0);
        @(negedge clk); status_err = 1'b0;
        idle(1);
    endtask

    task automatic t_hw_reset();
        wr(11'h000, 8'hB0);
        wr(11'h555, 8'hAA);
        @(negedge clk); hw_reset = 1'b1;
        @(negedge clk); hw_reset = 1'b0;
        check("R7 burst cleared", burst_mode, 0);
        check("R7 suspend cleared", erase_suspend, 0);
        check("R7 idle", seq_idle, 1);
        wr(11'h2AA, 8'h55); wr(11'h555, 8'hC0); wr(11'h000, 8'h01);
        check("R7 partial sequence dropped", burst_mode, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        idle(3);
        @(negedge clk); por_n = 1'b1;
        idle(1);
        t_reset_state();
        t_burst_enable();
        t_burst_disable();
        t_abort();
        t_gaps();
        t_soft_reset();
        t_err_hold();
        t_hw_reset();
        t_suspend();
        t_read_path();
        // R11: the single-pulse property is also tracked every cycle below
        idle(2);
        finish_run();
    end

    // R11 checked on every cycle
    always @(negedge clk) begin
        if (por_n && !done && $countones(pulses()) > 1) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 multiple pulses: actual %0b expected onehot0", pulses());
        end
    end

    initial begin
        #(5.0 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule